// File: doc/BRIEF.md
# Event Builder with Filtered Output Streams

This block joins one fragment from each of several input sources with the matching trigger accept to form a single event word. A trigger accept carries an event number and a small trigger-type field; every source presents one fragment, a word holding the source's event number and a data payload. When the trigger accept and all fragments are present, and no enabled output is full, the block builds the event in that same cycle. It pops the trigger entry and every source, and writes the event to the output streams that accept it.

Every fragment's event number is compared with the trigger's number. A source that disagrees is flagged in the event word. The event is still delivered. A sticky error flag and a saturating mismatch counter record the fault. There are four output streams with FIFO-style write ports. Stream 0 takes every event for the acquisition link. Streams 1 to 3 each apply a prescale and a masked trigger-type match. When any enabled output is full, the builder waits and drops nothing; a stall output reports that condition.

Top module: `event_builder`

## Requirements
- R1: An event is built in a cycle exactly when `trig_valid` is high, every bit of `src_valid` is high, and no enabled stream has its `out_full` bit set. In that cycle `trig_pop` and every bit of `src_pop` are high; in all other cycles they are all low.
- R2: In a build cycle `out_data` holds, from most to least significant, the per-source mismatch bits (bit i for source i), `trig_type`, `trig_evnum`, and the source payloads, with source 0 in the lowest DW bits.
- R3: A mismatch bit is 1 when that source's event number differs from `trig_evnum`. An event with mismatches is still built and written like any other.
- R4: `err_count` rises by one at the clock edge ending each build cycle that has at least one mismatch, and it saturates at 2^CW-1. `err_sticky` becomes 1 at the first such event and stays 1 until reset.
- R5: Stream 0 is always enabled, and `out_wr[0]` is high in every build cycle.
- R6: A filtered stream s (1..3) has a prescale P in `cfg_prescale` (field s-1, PW bits each). With P=0 the stream is disabled and never written. Otherwise its prescale test passes on the k-th built event since reset (k from 0) when k mod P equals P-1. This holds whether or not the header test passes.
- R7: A filtered stream is written only when both its prescale test passes and (`trig_type` & mask) == match, using its fields of `cfg_mask` and `cfg_match` (TW bits each, stream 1 in the lowest field).
- R8: A full flag on a disabled stream does not block building. While building is blocked by an enabled full stream with a complete input set, `stalled` is high, nothing is written, and the counters and flags keep their values.
- R9: While reset (`rst_n` low) is held, `err_sticky` and `err_count` are 0 and the prescale counters restart from event 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger accept entry present |
| trig_evnum | input | EW | Event number of the trigger accept |
| trig_type | input | TW | Trigger-type header bits |
| trig_pop | output | 1 | Consume the trigger accept entry |
| src_valid | input | N_SRC | Fragment present, one bit per source |
| src_evnum | input | N_SRC*EW | Fragment event numbers, source 0 lowest |
| src_data | input | N_SRC*DW | Fragment payloads, source 0 lowest |
| src_pop | output | N_SRC | Consume fragment, one bit per source |
| cfg_prescale | input | 3*PW | Prescale per filtered stream, 0 disables |
| cfg_mask | input | 3*TW | Header mask per filtered stream |
| cfg_match | input | 3*TW | Header match value per filtered stream |
| out_full | input | 4 | Full flag of each output stream |
| out_wr | output | 4 | Write strobe of each output stream |
| out_data | output | N_SRC+TW+EW+N_SRC*DW | Built event word shared by all streams |
| stalled | output | 1 | Complete inputs held back by a full enabled stream |
| err_sticky | output | 1 | A mismatched event has been seen since reset |
| err_count | output | CW | Saturating count of mismatched events |

## Verification
The hardest state to reach is a prescale counter at an exact phase relative to the trigger-type pattern. Header matches and prescale hits then coincide or miss in a known way. The bench resets before each prescale pair and sweeps every pair of small prescale values over enough events to wrap each counter. It then sweeps all trigger-type values against fixed mask and match settings. Counter saturation needs more mismatched events than the counter can hold, so the bench feeds a long run of deliberately wrong source numbers. It also holds a mismatched event behind a full stream to show that nothing moves until the stream drains.

// File: rtl/event_builder.sv
module event_builder #(
  parameter int N_SRC = 3,
  parameter int EW    = 8,
  parameter int DW    = 8,
  parameter int TW    = 4,
  parameter int PW    = 4,
  parameter int CW    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            trig_valid,
  input  logic [EW-1:0]                   trig_evnum,
  input  logic [TW-1:0]                   trig_type,
  output logic                            trig_pop,
  input  logic [N_SRC-1:0]                src_valid,
  input  logic [N_SRC*EW-1:0]             src_evnum,
  input  logic [N_SRC*DW-1:0]             src_data,
  output logic [N_SRC-1:0]                src_pop,
  input  logic [3*PW-1:0]                 cfg_prescale,
  input  logic [3*TW-1:0]                 cfg_mask,
  input  logic [3*TW-1:0]                 cfg_match,
  input  logic [3:0]                      out_full,
  output logic [3:0]                      out_wr,
  output logic [N_SRC+TW+EW+N_SRC*DW-1:0] out_data,
  output logic                            stalled,
  output logic                            err_sticky,
  output logic [CW-1:0]                   err_count
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [N_SRC-1:0] mis;
  logic [3:0]       en, pass;
  logic             ready, blocked, fire;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
    assign mis[i] = src_evnum[i*EW +: EW] != trig_evnum;
  end

  assign en[0]   = 1'b1;
  assign pass[0] = 1'b1;

  for (genvar s = 1; s < 4; s++) begin : g_stream
    logic [PW-1:0] p, cnt;
    logic          hit, hdr_ok;
    assign p      = cfg_prescale[(s-1)*PW +: PW];
    assign en[s]  = p != '0;
    assign hit    = en[s] && (cnt >= p - 1'b1);
    assign hdr_ok = (trig_type & cfg_mask[(s-1)*TW +: TW]) == cfg_match[(s-1)*TW +: TW];
    assign pass[s] = hit && hdr_ok;

    always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (fire && en[s]) cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  assign ready    = trig_valid && (&src_valid);
  assign blocked  = |(out_full & en);
  assign fire     = ready && !blocked;
  assign stalled  = ready && blocked;
  assign trig_pop = fire;
  assign src_pop  = {N_SRC{fire}};
  assign out_wr   = {4{fire}} & pass;
  assign out_data = {mis, trig_type, trig_evnum, src_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      err_count  <= '0;
    end else if (fire && |mis) begin
      err_sticky <= 1'b1;
      if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end
  end
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int N_SRC = 3,
  parameter int PW    = 4,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic [N_SRC-1:0] src_valid,
  input logic             trig_pop,
  input logic [N_SRC-1:0] src_pop,
  input logic [3:0]       out_full,
  input logic [3:0]       out_wr,
  input logic [3*PW-1:0]  cfg_prescale,
  input logic             stalled,
  input logic             err_sticky,
  input logic [CW-1:0]    err_count
);
  assert_pop_needs_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pop |-> (trig_valid && (&src_valid) && (&src_pop)));

  assert_stream0_every_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pop |-> out_wr[0]);

  assert_no_write_to_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr & out_full) == 4'b0000);

  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (out_wr == 4'b0000 && !trig_pop));

  assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  assert_count_implies_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != '0) |-> err_sticky);

  for (genvar s = 1; s < 4; s++) begin : g_off
    assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_prescale[(s-1)*PW +: PW] == '0) |-> !out_wr[s]);
  end
endmodule

bind event_builder eb_checker #(.N_SRC(N_SRC), .PW(PW), .CW(CW)) u_chk (.*);

// File: tb/test_event_builder.sv
module test_event_builder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid;
  logic [7:0]  trig_evnum;
  logic [3:0]  trig_type;
  logic        trig_pop;
  logic [2:0]  src_valid;
  logic [23:0] src_evnum;
  logic [23:0] src_data;
  logic [2:0]  src_pop;
  logic [11:0] cfg_prescale, cfg_mask, cfg_match;
  logic [3:0]  out_full, out_wr;
  logic [38:0] out_data;
  logic        stalled, err_sticky;
  logic [3:0]  err_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_builder i_event_builder (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trig_valid = 1'b0; src_valid = '0; out_full = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one event at a negedge, check combinational outputs, let it be taken at the edge
  task automatic present(input logic [3:0] typ, input logic [2:0] bad, input logic [7:0] evn,
                         input logic [23:0] pay);
    trig_valid = 1'b1; trig_evnum = evn; trig_type = typ;
    src_valid = 3'b111; src_data = pay;
    for (int i = 0; i < 3; i++) src_evnum[i*8 +: 8] = bad[i] ? evn + 8'd1 : evn;
    #1;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    trig_valid = 1'b0; src_valid = '0;
  endtask

  function automatic logic pre_hit(input int k, input int p);
    return (p != 0) && ((k % p) == p - 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] exp_wr;
    logic [3:0] exp_cnt;
    rst_n = 1'b0; trig_valid = 1'b0; trig_evnum = '0; trig_type = '0;
    src_valid = '0; src_evnum = '0; src_data = '0; out_full = '0;
    cfg_prescale = '0; cfg_mask = '0; cfg_match = '0;
    do_reset();
    #1;
    check("R9 sticky", err_sticky, 0);
    check("R9 count", err_count, 0);
    check("R1 idle pops", {trig_pop, src_pop}, 0);
    check("R1 idle wr", out_wr, 0);

    // partial inputs do not build
    @(negedge clk);
    trig_valid = 1'b1; src_valid = 3'b101; #1;
    check("R1 missing source", {trig_pop, src_pop, out_wr}, 0);
    trig_valid = 1'b0; src_valid = 3'b111; #1;
    check("R1 missing trigger", {trig_pop, src_pop, out_wr}, 0);
    src_valid = '0;

    // prescale sweep: streams 1,2 swept, stream 3 fixed at 2, no header filtering
    for (int p1 = 0; p1 < 4; p1++) begin
      for (int p2 = 0; p2 < 4; p2++) begin
        cfg_prescale = {4'd2, p2[3:0], p1[3:0]};
        cfg_mask = '0; cfg_match = '0;
        do_reset();
        for (int k = 0; k < 8; k++) begin
          present(k[3:0], 3'b000, 8'(k * 7 + p1), 24'(k * 24'h010203 + p2));
          exp_wr = {pre_hit(k, 2), pre_hit(k, p2), pre_hit(k, p1), 1'b1};
          check("R6 prescale writes", out_wr, exp_wr);
          check("R1 pops", {trig_pop, src_pop}, 4'b1111);
          check("R2 event word", out_data,
                {3'b000, k[3:0], 8'(k * 7 + p1), 24'(k * 24'h010203 + p2)});
          finish_cycle();
        end
      end
    end

    // header sweep, all prescales 1
    cfg_prescale = {4'd1, 4'd1, 4'd1};
    cfg_mask  = {4'b1000, 4'b1111, 4'b0011};
    cfg_match = {4'b1000, 4'b1010, 4'b0001};
    do_reset();
    for (int t = 0; t < 16; t++) begin
      present(t[3:0], 3'b000, 8'(t), 24'hABCDEF);
      exp_wr = {t[3] == 1'b1, t == 10, t[1:0] == 2'b01, 1'b1};
      check("R7 header select", out_wr, exp_wr);
      check("R5 stream0", out_wr[0], 1);
      finish_cycle();
    end

    // mismatch patterns, counts and saturation
    do_reset();
    exp_cnt = 0;
    for (int b = 0; b < 8; b++) begin
      present(4'h3, b[2:0], 8'h40, 24'h123456);
      check("R3 mismatch bits", out_data[38:36], b[2:0]);
      check("R3 still forwarded", out_wr[0] & trig_pop, 1);
      if (b != 0) exp_cnt++;
      finish_cycle();
      check("R4 count", err_count, exp_cnt);
      check("R4 sticky", err_sticky, b != 0);
    end
    for (int n = 0; n < 12; n++) begin
      present(4'h0, 3'b010, 8'(n), 24'h0);
      finish_cycle();
    end
    check("R4 saturation", err_count, 15);
    check("R4 sticky held", err_sticky, 1);

    // stall behaviour
    cfg_prescale = {4'd0, 4'd3, 4'd0};
    cfg_mask = '0; cfg_match = '0;
    do_reset();
    out_full = 4'b0010;
    present(4'h1, 3'b000, 8'h10, 24'h1);
    check("R8 disabled full ignored", {trig_pop, out_wr, stalled}, 6'b100010);
    finish_cycle();
    out_full = 4'b0100;
    present(4'h1, 3'b100, 8'h11, 24'h2);
    check("R8 enabled full stalls", {trig_pop, src_pop, out_wr, stalled}, 9'b000000001);
    finish_cycle();
    check("R8 count frozen", err_count, 0);
    out_full = 4'b0001;
    present(4'h1, 3'b100, 8'h11, 24'h2);
    check("R8 stream0 full stalls", {trig_pop, stalled}, 2'b01);
    finish_cycle();
    out_full = 4'b0000;
    present(4'h1, 3'b100, 8'h11, 24'h2);
    // second built event since reset: prescale 3 hits at k=2, not yet
    check("R8 release builds", {trig_pop, out_wr, stalled}, 6'b100010);
    finish_cycle();
    check("R8 count after release", err_count, 1);
    present(4'h1, 3'b000, 8'h12, 24'h3);
    check("R6 prescale after stall", out_wr, 4'b0101);
    finish_cycle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule